// File: doc/BRIEF.md
# Parity-Selectable (7,4) Hamming Syndrome Unit

This block checks and repairs a single 7-bit (7,4) Hamming code word. A strobe presents the word and a parity-sense select. On the clock edge that samples the strobe, the unit registers five results: the 3-bit syndrome, an error flag, a one-hot mask that marks the faulty bit, the repaired word, and the four recovered data bits. A valid pulse marks the cycle in which those results can be read. The results then hold until the next strobe.

A combinational encoder sits beside the checker. It builds the three check bits for a 4-bit value in either parity sense, so that words can be generated, corrupted and checked again for a round trip. Both halves use the same bit layout and the same parity-sense coding.

Top module: `hamming74_syndrome`

## Requirements
- R1: Code-word bit positions run 7 down to 1 as d4, d3, d2, c4, d1, c2, c1, where c1, c2 and c4 are check bits. The encoder places `enc_data[3:0]` = {d4,d3,d2,d1} into that layout. In even sense it sets c4 = d2^d3^d4, c2 = d1^d3^d4 and c1 = d1^d2^d4.
- R2: A parity-sense input of 1 selects even parity and 0 selects odd parity. In odd sense every check bit, in the encoder and in the syndrome, is the complement of its even-sense expression.
- R3: The syndrome {S3,S2,S1} is computed from the presented word. In even sense S3 = c4^d2^d3^d4, S2 = c2^d1^d3^d4 and S1 = c1^d1^d2^d4; in odd sense each bit is complemented.
- R4: `err` is 1 exactly when the registered syndrome is nonzero.
- R5: `err_mask[7:1]` has the single bit whose index equals a nonzero syndrome set, and is all zero for a zero syndrome. `fixed_word` is the presented word XOR that mask.
- R6: `data_out[3:0]` = {d4,d3,d2,d1} taken from `fixed_word`, that is bits 7, 6, 5 and 3.
- R7: The results are registered on the rising edge that samples `in_valid` high. `out_valid` is high during the cycle after that edge and low after any edge that samples `in_valid` low.
- R8: While `in_valid` is low, every registered result keeps its value.
- R9: While `rst_n` is low, every registered output is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Strobe: present a word for checking |
| cw_in | input | 7 | Code word, bits [7:1] |
| even_par | input | 1 | Parity sense for checking: 1 even, 0 odd |
| out_valid | output | 1 | High for one cycle after a strobe |
| syndrome | output | 3 | Registered {S3,S2,S1} |
| err | output | 1 | Nonzero-syndrome flag |
| err_mask | output | 7 | One-hot position of the faulty bit, [7:1] |
| fixed_word | output | 7 | Repaired code word, [7:1] |
| data_out | output | 4 | Recovered {d4,d3,d2,d1} |
| enc_data | input | 4 | Encoder input {d4,d3,d2,d1} |
| enc_even | input | 1 | Encoder parity sense: 1 even, 0 odd |
| enc_word | output | 7 | Encoded word, [7:1], combinational |

## Verification
The checked results are due one cycle after the strobe, and the encoder word is due within the same cycle as its inputs. The driver tags each expected item with the cycle number of its strobe. At the falling edge after each rising edge, the monitor requires `out_valid` on exactly the cycle after that tag and compares all five results. The encoder is checked within the cycle its inputs are applied. After idle gaps the bench compares the held results again to show that nothing moved.

// File: rtl/hamming74_syndrome.sv
module hamming74_syndrome (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:1] cw_in,
  input  logic       even_par,
  output logic       out_valid,
  output logic [2:0] syndrome,
  output logic       err,
  output logic [7:1] err_mask,
  output logic [7:1] fixed_word,
  output logic [3:0] data_out,
  input  logic [3:0] enc_data,
  input  logic       enc_even,
  output logic [7:1] enc_word
);
  logic [2:0] syn_c;
  logic [7:1] mask_c;

  assign syn_c[2] = cw_in[4] ^ cw_in[5] ^ cw_in[6] ^ cw_in[7] ^ ~even_par;
  assign syn_c[1] = cw_in[2] ^ cw_in[3] ^ cw_in[6] ^ cw_in[7] ^ ~even_par;
  assign syn_c[0] = cw_in[1] ^ cw_in[3] ^ cw_in[5] ^ cw_in[7] ^ ~even_par;

  for (genvar i = 1; i <= 7; i++) begin : g_mask
    assign mask_c[i] = (syn_c == 3'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      syndrome   <= '0;
      err        <= 1'b0;
      err_mask   <= '0;
      fixed_word <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        syndrome   <= syn_c;
        err        <= |syn_c;
        err_mask   <= mask_c;
        fixed_word <= cw_in ^ mask_c;
      end
    end
  end

  assign data_out = {fixed_word[7], fixed_word[6], fixed_word[5], fixed_word[3]};

  assign enc_word[7] = enc_data[3];
  assign enc_word[6] = enc_data[2];
  assign enc_word[5] = enc_data[1];
  assign enc_word[3] = enc_data[0];
  assign enc_word[4] = enc_data[1] ^ enc_data[2] ^ enc_data[3] ^ ~enc_even;
  assign enc_word[2] = enc_data[0] ^ enc_data[2] ^ enc_data[3] ^ ~enc_even;
  assign enc_word[1] = enc_data[0] ^ enc_data[1] ^ enc_data[3] ^ ~enc_even;
endmodule

module hamming74_syndrome_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:1] cw_in,
  input logic       out_valid,
  input logic [2:0] syndrome,
  input logic       err,
  input logic [7:1] err_mask,
  input logic [7:1] fixed_word,
  input logic       enc_even,
  input logic [7:1] enc_word
);
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(fixed_word) && $stable(syndrome) && $stable(err_mask) && $stable(err));
  p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err == (syndrome != 3'd0));
  p_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(err_mask) && ((fixed_word ^ $past(cw_in)) == err_mask));
  p_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (^{enc_word[7], enc_word[6], enc_word[5], enc_word[4]}) == ~enc_even &&
    (^{enc_word[7], enc_word[6], enc_word[3], enc_word[2]}) == ~enc_even &&
    (^{enc_word[7], enc_word[5], enc_word[3], enc_word[1]}) == ~enc_even);
endmodule

bind hamming74_syndrome hamming74_syndrome_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cw_in(cw_in),
  .out_valid(out_valid), .syndrome(syndrome), .err(err), .err_mask(err_mask),
  .fixed_word(fixed_word), .enc_even(enc_even), .enc_word(enc_word)
);

// File: tb/hamming74_syndrome_tb.sv
module hamming74_syndrome_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:1] cw_in = '0;
  logic       even_par = 1'b1;
  logic       out_valid;
  logic [2:0] syndrome;
  logic       err;
  logic [7:1] err_mask;
  logic [7:1] fixed_word;
  logic [3:0] data_out;
  logic [3:0] enc_data = '0;
  logic       enc_even = 1'b1;
  logic [7:1] enc_word;

  hamming74_syndrome u_dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0] syn;
    logic       e;
    logic [7:1] mask;
    logic [7:1] fix;
    logic [3:0] dat;
    int         cyc;
  } item_t;

  item_t q[$];
  item_t last;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] ref_syn(logic [7:1] w, logic ev);
    logic [2:0] s;
    for (int k = 0; k < 3; k++) begin
      s[k] = ~ev;
      for (int p = 1; p <= 7; p++) if (p[k]) s[k] ^= w[p];
    end
    return s;
  endfunction

  function automatic logic [7:1] ref_enc(logic [3:0] d, logic ev);
    logic [7:1] w;
    w = '0;
    w[7] = d[3]; w[6] = d[2]; w[5] = d[1]; w[3] = d[0];
    for (int k = 0; k < 3; k++) begin
      logic b;
      b = ~ev;
      for (int p = 3; p <= 7; p++) if (p[k] && p != 4) b ^= w[p];
      w[1 << k] = b;
    end
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic item_t model(logic [7:1] w, logic ev);
    item_t it;
    it.syn = ref_syn(w, ev);
    it.e = (it.syn != 0);
    for (int p = 1; p <= 7; p++) it.mask[p] = (it.syn == 3'(p));
    it.fix = w ^ it.mask;
    it.dat = {it.fix[7], it.fix[6], it.fix[5], it.fix[3]};
    it.cyc = 0;
    return it;
  endfunction

  task automatic cmp_item(item_t it);
    chk(syndrome == it.syn, "R3", "syndrome", 32'(syndrome), 32'(it.syn));
    chk(err == it.e, "R4", "err", 32'(err), 32'(it.e));
    chk(err_mask == it.mask, "R5", "err_mask", 32'(err_mask), 32'(it.mask));
    chk(fixed_word == it.fix, "R5", "fixed_word", 32'(fixed_word), 32'(it.fix));
    chk(data_out == it.dat, "R6", "data_out", 32'(data_out), 32'(it.dat));
  endtask

  // driver: strobe one word (called at a negedge), push expectation
  task automatic send(logic [7:1] w, logic ev, bit gap);
    item_t it;
    it = model(w, ev);
    it.cyc = cyc;
    cw_in = w; even_par = ev; in_valid = 1'b1;
    q.push_back(it);
    last = it;
    @(negedge clk);
    if (gap) begin
      in_valid = 1'b0;
      cw_in = ~w; even_par = ~ev;
      @(negedge clk);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) chk(0, "R7", "out_valid without strobe", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(cyc == it.cyc + 1, "R7", "result cycle", 32'(cyc), 32'(it.cyc + 1));
          cmp_item(it);
        end
      end else if (q.size() != 0 && cyc > q[0].cyc + 1) begin
        chk(0, "R7", "out_valid missing", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid == 0, "R9", "out_valid in reset", 32'(out_valid), 0);
    chk(syndrome == 0 && err == 0 && err_mask == 0 && fixed_word == 0 && data_out == 0,
        "R9", "outputs in reset", 32'({syndrome, err, err_mask, fixed_word}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // encoder (R1, R2) and round trips with every single-bit flip
    for (int ev = 0; ev < 2; ev++) begin
      for (int d = 0; d < 16; d++) begin
        logic [7:1] w;
        enc_data = 4'(d); enc_even = ev[0];
        #1;
        w = ref_enc(4'(d), ev[0]);
        chk(enc_word == w, ev ? "R1" : "R2", "enc_word", 32'(enc_word), 32'(w));
        send(enc_word, ev[0], d[0]);
        for (int p = 1; p <= 7; p++) begin
          logic [7:1] f;
          f = w; f[p] = ~f[p];
          send(f, ev[0], (p == 4));
        end
      end
    end

    // parity-sense mismatch: clean even word checked in odd sense (R2)
    send(ref_enc(4'hA, 1'b1), 1'b0, 1'b0);
    send(ref_enc(4'h3, 1'b0), 1'b1, 1'b1);

    // R8 hold: long idle, results must not move
    in_valid = 1'b0;
    repeat (4) begin
      cw_in = cw_in + 7'd13; even_par = ~even_par;
      @(negedge clk);
    end
    chk(out_valid == 0, "R7", "out_valid idle", 32'(out_valid), 0);
    cmp_item(last);
    chk(fixed_word == last.fix, "R8", "held fixed_word", 32'(fixed_word), 32'(last.fix));
    chk(q.size() == 0, "R7", "pending results", 32'(q.size()), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule